// File: doc/BRIEF.md
# Programmable Line Clamp Pulse Generator

This block produces one black-level clamp pulse per video line for an analog front end. It works in the pixel clock domain. It brings the horizontal sync input into that domain, finds the trailing edge of each sync pulse, and waits a programmable number of pixel periods (the placement). It then drives the clamp output high for a second programmable number of pixel periods (the duration). Both settings are 8-bit registers, written through a simple write-enable port. Each register resets to 0x80.

A mode input can select external clamping instead. In that mode the output copies an external clamp input, and the placement and duration settings play no part. A polarity input tells the block whether sync is active high or active low, and so which edge ends the sync pulse. The setting 0 is not supported in either register, so the block treats 0 as 1. A trailing edge that arrives while a pulse is still pending or running restarts the timing. Each new trailing edge takes a fresh copy of both settings, so a write never alters a pulse that has already started.

Top module: `line_clamp_gen`

## Requirements
- R1: After reset `clamp_out` is 0, and both the placement and duration registers hold 0x80. With no writes, a trailing edge gives a pulse that starts 128 periods late and lasts 128 periods.
- R2: With `hsync_active_low` = 0 the falling edge of `hsync_in` is the trailing edge. With `hsync_active_low` = 1 the rising edge is the trailing edge. Leading edges start nothing.
- R3: In internal mode, call the first rising clock edge that samples the trailing `hsync_in` level edge 1. `clamp_out` then goes high on edge P+4, where P is the effective placement. The four extra edges are two synchronizer stages, the edge register and the output register.
- R4: `clamp_out` stays high for exactly D clock periods, where D is the effective duration.
- R5: A register value of 0 behaves exactly like 1, for both placement and duration.
- R6: A trailing edge that arrives while a delay or a pulse is running restarts the delay from the new edge. A pulse that is high drops to 0 two clock edges after the synchronized trailing edge.
- R7: Writes to placement (`place_we`) or duration (`dur_we`) made during a line leave that line's pulse unchanged. They take effect from the next trailing edge.
- R8: With `ext_sel` = 1, `clamp_out` equals the `ext_clamp_in` value sampled on the previous rising clock edge. Sync edges and register settings have no effect in this mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hsync_in | input | 1 | Horizontal sync, asynchronous to clk |
| hsync_active_low | input | 1 | Sync polarity: 1 means sync is active low |
| ext_sel | input | 1 | 1 selects the external clamp input |
| ext_clamp_in | input | 1 | External clamp level |
| place_we | input | 1 | Write strobe for the placement register |
| dur_we | input | 1 | Write strobe for the duration register |
| cfg_wdata | input | W | Write data for either register |
| clamp_out | output | 1 | Registered clamp pulse to the front end |

## Verification
The bench measures the rise cycle and width of each pulse against values it computes from P and D. This catches an off-by-one in the delay or width counter, which would move or stretch every pulse by one period. Zero settings are tested because a design that loads 0 into a down-counter wraps and makes a 256-period delay or pulse. Retriggers are sent both during the delay and during the pulse. A design that ignores them keeps the stale timing, and one that does not drop the running pulse stretches it into the next line. Writes placed mid-line test the shadow copy. The external mode and both sync polarities are also covered, since swapping the edge shifts every pulse by the sync width.

// File: rtl/clamp_pkg.sv
package clamp_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_HOLD = 2'd2
   } clamp_state_e;
endpackage

// File: rtl/hsync_edge_det.sv
module hsync_edge_det #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hsync_in,
   input  logic active_low,
   output logic trail
);
   logic lvl_in;
   logic [STAGES-1:0] sync_q;
   logic prev_q;

   // normalise polarity before synchronising: 1 = sync active
   assign lvl_in = hsync_in ^ active_low;

   generate
      if (STAGES < 2) begin : g_bad
         $error("hsync_edge_det: STAGES must be at least 2");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) sync_q[0] <= 1'b0;
               else        sync_q[0] <= lvl_in;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) sync_q[s] <= 1'b0;
               else        sync_q[s] <= sync_q[s-1];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sync_q[STAGES-1];

   assign trail = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/clamp_cfg_reg.sv
module clamp_cfg_reg #(
   parameter int              W         = 8,
   parameter logic [W-1:0]    RESET_VAL = 'h80
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] value_eff
);
   localparam logic [W-1:0] ONE = W'(1);
   logic [W-1:0] val_q;

   generate
      if (W < 2) begin : g_bad_w
         $error("clamp_cfg_reg: W must be at least 2");
      end
      if (RESET_VAL == '0) begin : g_bad_rst
         $error("clamp_cfg_reg: RESET_VAL must be non-zero");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)  val_q <= RESET_VAL;
      else if (we) val_q <= wdata;

   // an unsupported zero setting behaves as the shortest legal one
   assign value_eff = (val_q == '0) ? ONE : val_q;
endmodule

// File: rtl/clamp_timer.sv
module clamp_timer
   import clamp_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         trail,
   input  logic [W-1:0] place,
   input  logic [W-1:0] dur,
   output logic         active
);
   localparam logic [W-1:0] ONE = W'(1);

   clamp_state_e state_q;
   logic [W-1:0] cnt_q;
   logic [W-1:0] dur_lat_q;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         cnt_q     <= '0;
         dur_lat_q <= ONE;
      end else if (trail) begin
         // every trailing edge restarts the line and takes fresh settings
         state_q   <= ST_WAIT;
         cnt_q     <= place - ONE;
         dur_lat_q <= dur;
      end else begin
         unique case (state_q)
            ST_WAIT:
               if (cnt_q == '0) begin
                  state_q <= ST_HOLD;
                  cnt_q   <= dur_lat_q - ONE;
               end else begin
                  cnt_q <= cnt_q - ONE;
               end
            ST_HOLD:
               if (cnt_q == '0) state_q <= ST_IDLE;
               else             cnt_q   <= cnt_q - ONE;
            default: state_q <= ST_IDLE;
         endcase
      end

   assign active = (state_q == ST_HOLD);
endmodule

// File: rtl/line_clamp_gen.sv
module line_clamp_gen #(
   parameter int           W           = 8,
   parameter logic [W-1:0] PLACE_RST   = 'h80,
   parameter logic [W-1:0] DUR_RST     = 'h80,
   parameter int           SYNC_STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         hsync_in,
   input  logic         hsync_active_low,
   input  logic         ext_sel,
   input  logic         ext_clamp_in,
   input  logic         place_we,
   input  logic         dur_we,
   input  logic [W-1:0] cfg_wdata,
   output logic         clamp_out
);
   logic         trail_evt;
   logic [W-1:0] place_eff;
   logic [W-1:0] dur_eff;
   logic         int_active;
   logic         clamp_q;

   hsync_edge_det #(.STAGES(SYNC_STAGES)) i_edge (
      .clk        (clk),
      .rst_n      (rst_n),
      .hsync_in   (hsync_in),
      .active_low (hsync_active_low),
      .trail      (trail_evt)
   );

   clamp_cfg_reg #(.W(W), .RESET_VAL(PLACE_RST)) i_place (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (place_we),
      .wdata     (cfg_wdata),
      .value_eff (place_eff)
   );

   clamp_cfg_reg #(.W(W), .RESET_VAL(DUR_RST)) i_dur (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (dur_we),
      .wdata     (cfg_wdata),
      .value_eff (dur_eff)
   );

   clamp_timer #(.W(W)) i_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .trail  (trail_evt),
      .place  (place_eff),
      .dur    (dur_eff),
      .active (int_active)
   );

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) clamp_q <= 1'b0;
      else        clamp_q <= ext_sel ? ext_clamp_in : int_active;

   assign clamp_out = clamp_q;
endmodule

// File: rtl/clamp_gen_chk.sv
module clamp_gen_chk #(
   parameter int W = 8
) (
   input logic clk,
   input logic rst_n,
   input logic ext_sel,
   input logic ext_clamp_in,
   input logic clamp_out,
   input logic trail_evt
);
   localparam int MAX_HIGH = (1 << W) - 1;

   logic        armed_q;
   logic [W:0]  high_cnt_q;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) armed_q <= 1'b0;
      else        armed_q <= 1'b1;

   // length of the current internal-mode high run, saturating
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                    high_cnt_q <= '0;
      else if (ext_sel || !clamp_out) high_cnt_q <= '0;
      else if (high_cnt_q != '1)      high_cnt_q <= high_cnt_q + 1'b1;

   always @(posedge clk)
      if (!rst_n) assert_reset_low_R1: assert (!clamp_out);

   assert_ext_follow_R8: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
      $past(ext_sel) |-> clamp_out == $past(ext_clamp_in));

   assert_retrigger_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (trail_evt && !ext_sel) ##1 !ext_sel |=> !clamp_out);

   assert_width_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !ext_sel |-> int'(high_cnt_q) <= MAX_HIGH);
endmodule

bind line_clamp_gen clamp_gen_chk #(.W(W)) i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .ext_sel      (ext_sel),
   .ext_clamp_in (ext_clamp_in),
   .clamp_out    (clamp_out),
   .trail_evt    (trail_evt)
);

// File: tb/test_line_clamp_gen.sv
module test_line_clamp_gen;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       hsync_in = 1'b1;
   logic       hsync_active_low = 1'b0;
   logic       ext_sel = 1'b0;
   logic       ext_clamp_in = 1'b0;
   logic       place_we = 1'b0;
   logic       dur_we = 1'b0;
   logic [7:0] cfg_wdata = '0;
   logic       clamp_out;

   int n_checks = 0;
   int n_errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   line_clamp_gen i_line_clamp_gen (
      .clk              (clk),
      .rst_n            (rst_n),
      .hsync_in         (hsync_in),
      .hsync_active_low (hsync_active_low),
      .ext_sel          (ext_sel),
      .ext_clamp_in     (ext_clamp_in),
      .place_we         (place_we),
      .dur_we           (dur_we),
      .cfg_wdata        (cfg_wdata),
      .clamp_out        (clamp_out)
   );

   function automatic int eff(input int v);
      return (v == 0) ? 1 : v;
   endfunction

   function automatic int exp_rise(input int p);
      return eff(p) + 4;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic act_lvl();
      return ~hsync_active_low;
   endfunction

   task automatic write_cfg(input int p, input int d);
      @(negedge clk); cfg_wdata = 8'(p); place_we = 1'b1;
      @(negedge clk); place_we = 1'b0; cfg_wdata = 8'(d); dur_we = 1'b1;
      @(negedge clk); dur_we = 1'b0;
   endtask

   // sync active for a few cycles, then the trailing edge; the loop index
   // counts clock edges from the first edge that samples the trailing level
   task automatic run_line(input int window, input int wr_at, input int wp, input int wd,
                           input int retrig_at,
                           output int r1, output int w1, output int r2, output int w2);
      logic prev = 1'b0;
      r1 = -1; w1 = 0; r2 = -1; w2 = 0;
      @(negedge clk); hsync_in = act_lvl();
      repeat (4) @(negedge clk);
      hsync_in = ~act_lvl();
      for (int i = 1; i <= window; i++) begin
         @(negedge clk);
         if (clamp_out && !prev) begin
            if (r1 < 0) r1 = i; else if (r2 < 0) r2 = i;
         end
         if (clamp_out) begin
            if (r2 < 0) w1++; else w2++;
         end
         prev = clamp_out;
         place_we = 1'b0; dur_we = 1'b0;
         if (i == wr_at)     begin cfg_wdata = 8'(wp); place_we = 1'b1; end
         if (i == wr_at + 1) begin cfg_wdata = 8'(wd); dur_we = 1'b1; end
         if (i == retrig_at)     hsync_in = act_lvl();
         if (i == retrig_at + 4) hsync_in = ~act_lvl();
      end
      place_we = 1'b0; dur_we = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      int r1, w1, r2, w2;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      check("R1 reset clamp low", int'(clamp_out), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 idle after reset", int'(clamp_out), 0);

      // R1: defaults 0x80 / 0x80
      run_line(300, -10, 0, 0, -10, r1, w1, r2, w2);
      check("R1 default placement rise", r1, exp_rise(128));
      check("R1 default duration width", w1, 128);

      // R2 / R3 / R4: directed small values, both polarities
      write_cfg(1, 1);
      run_line(40, -10, 0, 0, -10, r1, w1, r2, w2);
      check("R3 rise P=1", r1, exp_rise(1));
      check("R4 width D=1", w1, 1);
      check("R2 leading edge starts nothing", r2, -1);
      @(negedge clk); hsync_active_low = 1'b1; hsync_in = 1'b1;
      repeat (4) @(negedge clk);
      write_cfg(9, 5);
      run_line(60, -10, 0, 0, -10, r1, w1, r2, w2);
      check("R2 active-low rise", r1, exp_rise(9));
      check("R2 active-low width", w1, 5);
      check("R2 active-low single pulse", r2, -1);

      // R5: zero settings
      write_cfg(0, 0);
      run_line(40, -10, 0, 0, -10, r1, w1, r2, w2);
      check("R5 zero placement as one", r1, exp_rise(0));
      check("R5 zero duration as one", w1, 1);
      write_cfg(255, 2);
      run_line(300, -10, 0, 0, -10, r1, w1, r2, w2);
      check("R3 max placement rise", r1, exp_rise(255));
      check("R4 width D=2", w1, 2);

      // R6: retrigger during delay, then during the pulse
      write_cfg(20, 6);
      run_line(80, -10, 0, 0, 5, r1, w1, r2, w2);
      check("R6 retrigger in delay rise", r1, 9 + exp_rise(20));
      check("R6 retrigger in delay width", w1, 6);
      write_cfg(3, 30);
      run_line(80, -10, 0, 0, 10, r1, w1, r2, w2);
      check("R6 first pulse rise", r1, exp_rise(3));
      check("R6 first pulse cut", w1, 11);
      check("R6 second pulse rise", r2, 14 + exp_rise(3));
      check("R6 second pulse width", w2, 30);

      // R7: write mid-line
      write_cfg(30, 10);
      run_line(60, 5, 7, 3, -10, r1, w1, r2, w2);
      check("R7 mid-line write keeps rise", r1, exp_rise(30));
      check("R7 mid-line write keeps width", w1, 10);
      run_line(40, -10, 0, 0, -10, r1, w1, r2, w2);
      check("R7 next line new rise", r1, exp_rise(7));
      check("R7 next line new width", w1, 3);

      // R3 / R4 / R2 random lines
      for (int k = 0; k < 24; k++) begin
         int p, d;
         p = int'($urandom_range(0, 40));
         d = int'($urandom_range(0, 40));
         @(negedge clk);
         hsync_active_low = 1'($urandom_range(0, 1));
         hsync_in = hsync_active_low;
         repeat (4) @(negedge clk);
         write_cfg(p, d);
         run_line(100, -10, 0, 0, -10, r1, w1, r2, w2);
         check("R3 random rise", r1, exp_rise(p));
         check("R4 random width", w1, eff(d));
      end

      // R8: external mode follows input, ignores sync and settings
      write_cfg(1, 1);
      @(negedge clk); ext_sel = 1'b1; ext_clamp_in = 1'b0;
      begin
         logic last;
         last = 1'b0;
         for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            check("R8 external follow", int'(clamp_out), int'(last));
            last = (i < 30) ? 1'($urandom_range(0, 1)) : 1'b0;
            ext_clamp_in = last;
            hsync_in = (i % 6 < 3) ? act_lvl() : ~act_lvl();
         end
         hsync_in = ~act_lvl();
      end
      @(negedge clk); ext_sel = 1'b0;
      repeat (10) @(negedge clk);
      check("R8 back to internal idle", int'(clamp_out), 0);

      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule